// File: doc/BRIEF.md
# Receive Descriptor Chain DMA Engine

This block moves received frames from a byte stream into memory buffers that software describes with a linked list of 32-byte descriptors. Software writes the address of the first descriptor, sets the enable bit and writes the pointer-valid bit. The engine then reads four words of the descriptor: the buffer address, the next-pointer low word, the next-pointer high word (bit 31 marks the last descriptor) and the configuration word (buffer size in bits 31:16, owner bit 15). It stores each frame little-endian into the buffer. It then writes the stored byte count and a status word back into the same descriptor, with the owner bit cleared. Next it either follows the next pointer or, after a last descriptor, raises a sticky end-of-queue flag and stops.

The sequencer has these states. IDLE drops incoming frames and counts them. FBUF, FNLO, FNHI and FCFG fetch descriptor words. RECV accepts bytes. WDATA stores a packed word. WCNT and WSTAT write back the descriptor. NEXT picks the following step. Transitions: IDLE→FBUF on a pending start when no dropped frame is half-way through. FBUF→FNLO→FNHI→FCFG, each on a memory acknowledge. FCFG→RECV when the owner bit is 1, FCFG→IDLE when it is 0. RECV→WDATA when a word fills or a frame ends with bytes pending. RECV→WCNT when a frame ends with nothing pending. WDATA→RECV during a frame, WDATA→WCNT at its end. WCNT→WSTAT→NEXT on acknowledges. NEXT→FBUF to follow the chain, NEXT→IDLE after a last descriptor or when enable is clear.

Register map (word index on `csr_waddr`/`csr_raddr`): 0 queue pointer low. 1 pointer high, where a write with bit 31 starts the engine and a read returns busy in bit 31. 2 control, with enable in bit 0. 3 status, with end-of-queue in bit 0, cleared by writing 1. 4 dropped-frame count, read only.

Top module: `rxq_dma`

## Requirements
- R1: After reset no memory request is issued, the engine reads as not busy, end-of-queue is 0, the dropped-frame count is 0 and `rx_ready` is 1.
- R2: Writing 1 to bit 31 of register 1 while enable (register 2 bit 0) is 1 starts fetching at the register 0 address, and the engine can be restarted this way after it stops.
- R3: If the fetched configuration word has owner bit 15 equal to 0, the engine stops without writing memory. Each frame that arrives while it is stopped is dropped and adds 1 to register 4.
- R4: Frame byte k is stored in buffer word k/4, at bits 8*(k%4)+7 down to 8*(k%4). Bytes past the end of the frame in its last word are written as 0.
- R5: On completion, descriptor word 4 is written with the number of stored bytes in bits 15:0 and zeros above.
- R6: Descriptor word 5 is written back with the buffer size kept in bits 31:16, owner bit 15 cleared, end-of-frame bit 0 and start-of-frame bit 1 set, and short-frame bit 4 set when fewer than MIN_FRAME bytes were stored.
- R7: Bytes beyond the buffer size are not stored, and no memory word past the buffer is touched. Max-length bit 11 and bad-frame bit 8 are set in the status word.
- R8: A frame whose last beat carries `rx_err` gets CRC-error bit 12 and bad-frame bit 8 in its status word.
- R9: When next-pointer high bit 31 is 0, the engine continues at the next-pointer low address with its low 5 bits ignored. Descriptor pointers written to register 0 also have their low 5 bits ignored.
- R10: After the status write of a descriptor whose next-pointer high bit 31 is 1, register 3 bit 0 becomes 1 and the engine stops. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R11: A pointer-valid write while enable is 0 starts nothing, and frames keep being dropped and counted.
- R12: A memory request holds its address and direction until `mem_ack`, and `rx_ready` is 0 while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_waddr | input | 3 | Register write word index |
| csr_wdata | input | 32 | Register write data |
| csr_raddr | input | 3 | Register read word index |
| csr_rdata | output | 32 | Register read data (combinational) |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of frame |
| rx_err | input | 1 | Frame error, meaningful with rx_last |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory response, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The assertions take for granted that `mem_ack` is a single-cycle pulse given only while a request is pending, and that the frame stream changes a beat only after it has been taken with `rx_ready` high. The bench memory model acknowledges every request exactly one cycle after it sees it and then drops the acknowledge for one cycle. Frame beats are driven on the falling edge and held until `rx_ready` is seen high, so both assumptions hold throughout the run.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FBUF,
        ST_FNLO,
        ST_FNHI,
        ST_FCFG,
        ST_RECV,
        ST_WDATA,
        ST_WCNT,
        ST_WSTAT,
        ST_NEXT
    } rxq_state_e;

    // descriptor word indices
    localparam int DW_BUF    = 0;
    localparam int DW_NXT_LO = 2;
    localparam int DW_NXT_HI = 3;
    localparam int DW_CNT    = 4;
    localparam int DW_CFG    = 5;

    // register word indices
    localparam logic [2:0] RA_PTR  = 3'd0;
    localparam logic [2:0] RA_VLD  = 3'd1;
    localparam logic [2:0] RA_CTL  = 3'd2;
    localparam logic [2:0] RA_STAT = 3'd3;
    localparam logic [2:0] RA_DROP = 3'd4;

    function automatic logic [31:0] word_off(input int w);
        return 32'(w * 4);
    endfunction

endpackage

// File: rtl/rxq_regs.sv
module rxq_regs #(
    parameter int DROP_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [2:0]  waddr,
    input  logic [31:0] wdata,
    input  logic [2:0]  raddr,
    output logic [31:0] rdata,
    output logic [31:0] start_addr,
    output logic        start_pend,
    input  logic        start_ack,
    output logic        go,
    input  logic        eoq_set,
    output logic        eoq,
    input  logic        drop_inc,
    input  logic        busy
);
    import rxq_pkg::*;

    logic [31:0]       ptr_q;
    logic              go_q;
    logic              eoq_q;
    logic              pend_q;
    logic [DROP_W-1:0] drop_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            go_q   <= 1'b0;
            eoq_q  <= 1'b0;
            pend_q <= 1'b0;
            drop_q <= '0;
        end else begin
            if (start_ack)
                pend_q <= 1'b0;
            if (we && waddr == RA_PTR)
                ptr_q <= wdata;
            if (we && waddr == RA_VLD && wdata[31] && go_q)
                pend_q <= 1'b1;
            if (we && waddr == RA_CTL)
                go_q <= wdata[0];
            if (we && waddr == RA_STAT && wdata[0])
                eoq_q <= 1'b0;
            if (eoq_set)
                eoq_q <= 1'b1;
            if (drop_inc)
                drop_q <= drop_q + 1'b1;
        end
    end

    always_comb begin
        unique case (raddr)
            RA_PTR:  rdata = ptr_q;
            RA_VLD:  rdata = {busy, 31'b0};
            RA_CTL:  rdata = {31'b0, go_q};
            RA_STAT: rdata = {31'b0, eoq_q};
            RA_DROP: rdata = 32'(drop_q);
            default: rdata = '0;
        endcase
    end

    assign start_addr = {ptr_q[31:5], 5'b0};
    assign start_pend = pend_q;
    assign go         = go_q;
    assign eoq        = eoq_q;

endmodule

// File: rtl/rxq_pack.sv
module rxq_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic [1:0]  lane,
    input  logic [7:0]  byte_in,
    output logic [31:0] word
);
    logic [31:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (push) begin
            if (lane == 2'd0)
                word_q <= {24'b0, byte_in};
            else
                word_q[{lane, 3'b000} +: 8] <= byte_in;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/rxq_seq.sv
module rxq_seq #(
    parameter int CNT_W     = 16,
    parameter int MIN_FRAME = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        start_pend,
    input  logic [31:0] start_addr,
    output logic        start_ack,
    output logic        eoq_set,
    output logic        drop_inc,
    output logic        busy,
    input  logic        rx_valid,
    input  logic        rx_last,
    input  logic        rx_err,
    output logic        rx_ready,
    output logic        pk_push,
    output logic [1:0]  pk_lane,
    input  logic [31:0] pk_word,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    import rxq_pkg::*;

    rxq_state_e state_q, state_d;

    logic [31:0]      desc_q;
    logic [31:0]      buf_q;
    logic [31:5]      next_q;
    logic             last_q;
    logic [CNT_W-1:0] size_q;
    logic [CNT_W-1:0] cnt_q;
    logic             trunc_q;
    logic             crc_q;
    logic             done_q;
    logic             mid_q;
    logic [31:0]      waddr_q;

    logic             stored;
    logic [CNT_W-1:0] new_cnt;
    logic             need_wr;
    logic             start_go;
    logic             bad;
    logic             short_f;
    logic [31:0]      status_w;

    assign stored   = cnt_q < size_q;
    assign new_cnt  = cnt_q + CNT_W'(stored);
    assign need_wr  = (stored && cnt_q[1:0] == 2'd3) || (rx_last && new_cnt[1:0] != 2'd0);
    assign start_go = start_pend && !mid_q && !(rx_valid && !rx_last);
    assign bad      = trunc_q || crc_q;
    assign short_f  = cnt_q < CNT_W'(MIN_FRAME);
    assign status_w = {16'(size_q), 3'b000, crc_q, trunc_q, 2'b00, bad,
                       3'b000, short_f, 2'b00, 2'b11};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_go) state_d = ST_FBUF;
            ST_FBUF:  if (mem_ack) state_d = ST_FNLO;
            ST_FNLO:  if (mem_ack) state_d = ST_FNHI;
            ST_FNHI:  if (mem_ack) state_d = ST_FCFG;
            ST_FCFG:  if (mem_ack) state_d = mem_rdata[15] ? ST_RECV : ST_IDLE;
            ST_RECV:  if (rx_valid)
                          state_d = need_wr ? ST_WDATA : (rx_last ? ST_WCNT : ST_RECV);
            ST_WDATA: if (mem_ack) state_d = done_q ? ST_WCNT : ST_RECV;
            ST_WCNT:  if (mem_ack) state_d = ST_WSTAT;
            ST_WSTAT: if (mem_ack) state_d = ST_NEXT;
            ST_NEXT:  state_d = (last_q || !go) ? ST_IDLE : ST_FBUF;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_q;
        mem_wdata = '0;
        rx_ready  = 1'b0;
        drop_inc  = 1'b0;
        start_ack = 1'b0;
        eoq_set   = 1'b0;
        pk_push   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rx_ready  = 1'b1;
                drop_inc  = rx_valid && rx_last;
                start_ack = start_go;
            end
            ST_FBUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + word_off(DW_BUF);
            end
            ST_FNLO: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + word_off(DW_NXT_LO);
            end
            ST_FNHI: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + word_off(DW_NXT_HI);
            end
            ST_FCFG: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + word_off(DW_CFG);
            end
            ST_RECV: begin
                rx_ready = 1'b1;
                pk_push  = rx_valid && stored;
            end
            ST_WDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = waddr_q;
                mem_wdata = pk_word;
            end
            ST_WCNT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q + word_off(DW_CNT);
                mem_wdata = 32'(cnt_q);
            end
            ST_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_q + word_off(DW_CFG);
                mem_wdata = status_w;
            end
            ST_NEXT: eoq_set = last_q;
            default: ;
        endcase
    end

    assign busy    = state_q != ST_IDLE;
    assign pk_lane = cnt_q[1:0];

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q  <= '0;
            buf_q   <= '0;
            next_q  <= '0;
            last_q  <= 1'b0;
            size_q  <= '0;
            cnt_q   <= '0;
            trunc_q <= 1'b0;
            crc_q   <= 1'b0;
            done_q  <= 1'b0;
            mid_q   <= 1'b0;
            waddr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rx_valid)
                        mid_q <= !rx_last;
                    if (start_go)
                        desc_q <= start_addr;
                end
                ST_FBUF: if (mem_ack) buf_q <= mem_rdata;
                ST_FNLO: if (mem_ack) next_q <= mem_rdata[31:5];
                ST_FNHI: if (mem_ack) last_q <= mem_rdata[31];
                ST_FCFG: if (mem_ack) begin
                    size_q  <= mem_rdata[31:16];
                    cnt_q   <= '0;
                    trunc_q <= 1'b0;
                    crc_q   <= 1'b0;
                    done_q  <= 1'b0;
                end
                ST_RECV: if (rx_valid) begin
                    cnt_q   <= new_cnt;
                    trunc_q <= trunc_q || !stored;
                    crc_q   <= crc_q || (rx_last && rx_err);
                    done_q  <= rx_last;
                    waddr_q <= buf_q + 32'((new_cnt - CNT_W'(1)) & ~CNT_W'(3));
                end
                ST_NEXT: if (!last_q) desc_q <= {next_q, 5'b0};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rxq_dma.sv
module rxq_dma #(
    parameter int CNT_W     = 16,
    parameter int MIN_FRAME = 64,
    parameter int DROP_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [2:0]  csr_waddr,
    input  logic [31:0] csr_wdata,
    input  logic [2:0]  csr_raddr,
    output logic [31:0] csr_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_err,
    output logic        rx_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    logic [31:0] start_addr;
    logic        start_pend;
    logic        start_ack;
    logic        go;
    logic        eoq_set;
    logic        eoq_flag;
    logic        drop_inc;
    logic        busy;
    logic        pk_push;
    logic [1:0]  pk_lane;
    logic [31:0] pk_word;

    rxq_regs #(.DROP_W(DROP_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (csr_we),
        .waddr      (csr_waddr),
        .wdata      (csr_wdata),
        .raddr      (csr_raddr),
        .rdata      (csr_rdata),
        .start_addr (start_addr),
        .start_pend (start_pend),
        .start_ack  (start_ack),
        .go         (go),
        .eoq_set    (eoq_set),
        .eoq        (eoq_flag),
        .drop_inc   (drop_inc),
        .busy       (busy)
    );

    rxq_pack u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (pk_push),
        .lane    (pk_lane),
        .byte_in (rx_data),
        .word    (pk_word)
    );

    rxq_seq #(.CNT_W(CNT_W), .MIN_FRAME(MIN_FRAME)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .start_pend (start_pend),
        .start_addr (start_addr),
        .start_ack  (start_ack),
        .eoq_set    (eoq_set),
        .drop_inc   (drop_inc),
        .busy       (busy),
        .rx_valid   (rx_valid),
        .rx_last    (rx_last),
        .rx_err     (rx_err),
        .rx_ready   (rx_ready),
        .pk_push    (pk_push),
        .pk_lane    (pk_lane),
        .pk_word    (pk_word),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

endmodule

// File: rtl/rxq_dma_chk.sv
module rxq_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        rx_ready,
    input logic        eoq,
    input logic        csr_we,
    input logic [2:0]  csr_waddr,
    input logic [31:0] csr_wdata
);
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12
    rx_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && mem_req));

    // R10
    eoq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoq && !(csr_we && csr_waddr == 3'd3 && csr_wdata[0])) |=> eoq);

    // R10
    eoq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoq) |-> $past(mem_we && mem_ack, 2));

endmodule

bind rxq_dma rxq_dma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .rx_ready  (rx_ready),
    .eoq       (eoq_flag),
    .csr_we    (csr_we),
    .csr_waddr (csr_waddr),
    .csr_wdata (csr_wdata)
);

// File: tb/rxq_dma_tb.sv
module rxq_dma_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_waddr = '0;
    logic [31:0] csr_wdata = '0;
    logic [2:0]  csr_raddr = '0;
    logic [31:0] csr_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        ack_q = 1'b0;
    logic [31:0] rdata_q = '0;

    rxq_dma u_dut (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
        .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(ack_q), .mem_rdata(rdata_q)
    );

    logic [31:0] mem [256];

    always @(posedge clk) begin
        if (mem_req && !ack_q) begin
            ack_q <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        rdata_q <= mem[mem_addr[9:2]];
        end else begin
            ack_q <= 1'b0;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    localparam logic [31:0] SENT = 32'hA5A5_5A5A;

    // {frame length, buffer size, error on last beat}
    localparam logic [32:0] VEC [6] = '{
        {16'd8,  16'd64,  1'b0},
        {16'd70, 16'd128, 1'b0},
        {16'd10, 16'd6,   1'b0},
        {16'd5,  16'd8,   1'b1},
        {16'd13, 16'd12,  1'b1},
        {16'd4,  16'd4,   1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_waddr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_raddr = a;
        #2 d = csr_rdata;
    endtask

    task automatic set_desc(input int w, input logic [31:0] bufa, input logic [31:0] nxt,
                            input logic last, input logic [15:0] size, input logic own);
        mem[w]   = bufa;
        mem[w+1] = '0;
        mem[w+2] = nxt;
        mem[w+3] = {last, 31'b0};
        mem[w+4] = '0;
        mem[w+5] = {size, own, 15'b0};
    endtask

    task automatic fill_sent();
        for (int i = 64; i < 256; i++) mem[i] = SENT;
    endtask

    task automatic start(input logic [31:0] p);
        csr_wr(3'd0, p);
        csr_wr(3'd1, 32'h8000_0000);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input logic err, input logic [7:0] seed);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = seed + 8'(i);
            rx_last  = (i == len - 1);
            rx_err   = (i == len - 1) && err;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int k = 0; k < 1000; k++) begin
            csr_rd(3'd1, d);
            if (!d[31]) break;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d, d0, exp;
        int len, size, stored, nw;
        logic err, trunc;
        logic [7:0] seed;
        string tag;

        for (int i = 0; i < 256; i++) mem[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
        csr_rd(3'd1, d); chk("R1 busy", d, 32'd0);
        csr_rd(3'd3, d); chk("R1 eoq", d, 32'd0);
        csr_rd(3'd4, d); chk("R1 drops", d, 32'd0);

        csr_wr(3'd2, 32'd1);

        // table of frames, each in one last-flagged descriptor
        for (int v = 0; v < 6; v++) begin
            len  = int'(VEC[v][32:17]);
            size = int'(VEC[v][16:1]);
            err  = VEC[v][0];
            seed = 8'(v * 16 + 1);
            fill_sent();
            set_desc(0, 32'h100, 32'h0, 1'b1, 16'(size), 1'b1);
            csr_wr(3'd3, 32'd1);
            start(v == 0 ? 32'h0000_0007 : 32'h0); // R9 low pointer bits ignored
            send_frame(len, err, seed);
            wait_idle();
            stored = (len < size) ? len : size;
            trunc  = len > size;
            nw     = (stored + 3) / 4;
            for (int w = 0; w < nw; w++) begin
                exp = '0;
                for (int b = 0; b < 4; b++)
                    if (w * 4 + b < stored) exp[b*8 +: 8] = seed + 8'(w * 4 + b);
                chk("R4 buffer word", mem[64 + w], exp);
            end
            chk("R7 word past stored data untouched", mem[64 + nw], SENT);
            chk("R5 byte count", mem[4], 32'(stored));
            exp = {16'(size), 3'b000, err, trunc, 2'b00, err | trunc,
                   3'b000, stored < 64, 2'b00, 2'b11};
            tag = trunc ? "R7 status" : (err ? "R8 status" : "R6 status");
            chk(tag, mem[5], exp);
            csr_rd(3'd3, d); chk("R10 eoq set", d, 32'd1);
        end

        // R10 write-1-to-clear
        csr_wr(3'd3, 32'd0);
        csr_rd(3'd3, d); chk("R10 write 0 keeps eoq", d, 32'd1);
        csr_wr(3'd3, 32'd1);
        csr_rd(3'd3, d); chk("R10 write 1 clears eoq", d, 32'd0);

        // R9 two-descriptor chain, next pointer with stray low bits
        fill_sent();
        set_desc(0, 32'h100, 32'h0000_0053, 1'b0, 16'd64, 1'b1);
        set_desc(16, 32'h200, 32'h0, 1'b1, 16'd64, 1'b1);
        start(32'h0);
        send_frame(5, 1'b0, 8'h30);
        send_frame(9, 1'b0, 8'h60);
        wait_idle();
        chk("R5 first count", mem[4], 32'd5);
        chk("R9 second count", mem[20], 32'd9);
        chk("R9 second buffer", mem[128], 32'h6362_6160);
        chk("R9 second status", mem[21], {16'd64, 16'h0013});
        csr_rd(3'd3, d); chk("R10 eoq after chain", d, 32'd1);

        // R3 owner bit clear stops the engine
        fill_sent();
        set_desc(0, 32'h100, 32'h0, 1'b1, 16'd64, 1'b0);
        csr_wr(3'd3, 32'd1);
        csr_rd(3'd4, d0);
        start(32'h0);
        repeat (20) @(negedge clk);
        csr_rd(3'd1, d); chk("R3 stopped", d, 32'd0);
        send_frame(6, 1'b0, 8'h11);
        repeat (3) @(negedge clk);
        csr_rd(3'd4, d); chk("R3 drop counted", d, d0 + 1);
        chk("R3 descriptor untouched", mem[5], {16'd64, 16'h0000});
        chk("R3 buffer untouched", mem[64], SENT);

        // R11 enable clear: pointer-valid write ignored
        csr_wr(3'd2, 32'd0);
        set_desc(0, 32'h100, 32'h0, 1'b1, 16'd64, 1'b1);
        start(32'h0);
        repeat (20) @(negedge clk);
        csr_rd(3'd1, d); chk("R11 not started", d, 32'd0);
        chk("R11 descriptor untouched", mem[5], {16'd64, 16'h8000});
        send_frame(3, 1'b0, 8'h22);
        repeat (3) @(negedge clk);
        csr_rd(3'd4, d); chk("R11 drop counted", d, d0 + 2);

        // R2 restart after stop
        csr_wr(3'd2, 32'd1);
        start(32'h0);
        send_frame(4, 1'b0, 8'h40);
        wait_idle();
        chk("R2 restart count", mem[4], 32'd4);
        chk("R2 restart data", mem[64], 32'h4342_4140);

        finish_run();
    end

endmodule